// File: doc/BRIEF.md
# Inverter Leg Gate Command Conditioner

This block takes the two switch commands of one inverter half-bridge, a high-side command and a low-side command, and turns them into two gate-enable outputs that are safe to hand to the power stage. Both commands are active-high: a 1 asks for the switch to be on. Each command is first brought into the clock domain by a two-flop synchronizer. It then passes a symmetric glitch filter that moves a new level to its output only after that level has held for `FILT_CYC` clock cycles. Both edges are filtered.

The filtered commands drive a small state machine that arbitrates the leg. Whichever side became active first owns the leg, and the other side waits. Every turn-off is followed by a dead time of `DEAD_CYC` cycles in which both outputs stay low. A protection input, `trip`, forces both outputs low in the same cycle and clears the arbitration state. Three instances give a three-phase drive. All timing is in clock cycles. For example, 29 and 38 cycles at 100 MHz give about 290 ns of filtering and 380 ns of dead time.

The state machine has five states. `S_IDLE`: nothing owns the leg. `S_HI` and `S_LO`: one side is driven. `S_DEAD`: the dead time is running. `S_BLOCK`: both commands rose together. Its transitions are as follows.
- `S_IDLE` goes to `S_HI` or `S_LO` when exactly one command is present, and to `S_BLOCK` when both are present.
- `S_HI` and `S_LO` go to `S_DEAD` when their own command drops.
- `S_DEAD` leaves when its count expires. It goes to the requesting side, to the side that was waiting if both request, to `S_BLOCK` if both request with no previous owner, or to `S_IDLE`.
- `S_BLOCK` goes to the side that remains once the other command is released, or to `S_IDLE` if neither remains.
- Reset enters `S_DEAD`. A trip holds the machine in `S_DEAD` with its count at zero.

Top module: `leg_gate_cond`

## Requirements
- R1: After reset both `hi_gate` and `lo_gate` are 0. The commands are active-high: 1 requests the switch on.
- R2: A command level that changes and then holds changes the matching gate output on the (FILT_CYC+3)-th rising edge. The edge that first samples the new level counts as the first. This latency is the same for turn-on and turn-off.
- R3: A command pulse of either polarity that lasts fewer than FILT_CYC cycles leaves the gate outputs unchanged. A pulse of exactly FILT_CYC cycles is passed.
- R4: While one gate output is on, asserting the other command does not turn the other output on, and the owning output stays on.
- R5: When the owning command is released while the other command is held, the other output turns on exactly DEAD_CYC cycles after the owning output turns off.
- R6: Every rising edge of either gate output is preceded by at least DEAD_CYC consecutive cycles in which both outputs are 0.
- R7: `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R8: If both filtered commands become active in the same cycle, neither output turns on. Once one command is released, the other output turns on with the R2 latency counted from the release.
- R9: While `trip` is 1, both outputs are 0 in that same cycle, whatever the commands are.
- R10: After `trip` is released with a command held, that output turns on at the rising edge numbered max(DEAD_CYC, FILT_CYC+1), counting the first edge that samples `trip` low as 1. The dead time restarts and the command is filtered again.
- R11: If both commands are active when the dead time after an owner's turn-off expires, the side that was waiting wins, even when the former owner re-asserted its command during the dead time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | High-side command, asynchronous, active-high |
| lo_cmd | input | 1 | Low-side command, asynchronous, active-high |
| trip | input | 1 | Protection shutdown, synchronous, active-high |
| hi_gate | output | 1 | High-side gate enable |
| lo_gate | output | 1 | Low-side gate enable |

## Verification
A command level changes an output FILT_CYC+3 rising edges after it is first sampled. That is two synchronizer flops, FILT_CYC matching samples, and one state-register edge. A handover adds exactly DEAD_CYC cycles after the owner falls, and a trip release takes max(DEAD_CYC, FILT_CYC+1) edges. A trip acts on the outputs in the same cycle. The bench drives inputs on falling edges and counts rising edges from there. For each of these latencies it checks that the output has not yet moved one edge before it is due and has moved at the edge it is due. Filter rejection is checked by watching the outputs on every cycle of a window longer than the latency after a pulse one cycle short of FILT_CYC. Dead time and mutual exclusion are watched on every cycle by a monitor.

// File: rtl/leg_pkg.sv
package leg_pkg;

    // Arbitration states of one half-bridge leg.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_HI    = 3'd1,
        S_LO    = 3'd2,
        S_DEAD  = 3'd3,
        S_BLOCK = 3'd4
    } leg_state_e;

    // Which side owned the leg before the current dead time.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_HI   = 2'd1,
        OWN_LO   = 2'd2
    } leg_owner_e;

    // Channel indices inside the two-bit command vector.
    localparam int unsigned CH_HI = 0;
    localparam int unsigned CH_LO = 1;
    localparam int unsigned N_CH  = 2;

endpackage

// File: rtl/leg_sync2.sv
module leg_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign q_sync = sync_q;

endmodule

// File: rtl/leg_glitch_filter.sv
module leg_glitch_filter #(
    parameter int unsigned FILT_CYC = 29
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic raw,
    output logic filt
);

    localparam int unsigned CW  = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_CYC - 1);

    typedef enum logic {
        F_LOW  = 1'b0,
        F_HIGH = 1'b1
    } filt_state_e;

    filt_state_e   st_q;
    filt_state_e   st_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          differs;

    assign differs = (raw != logic'(st_q));

    // Next-state: a level flips the state only after LIM+1 differing samples.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (flush) begin
            st_d  = F_LOW;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                F_LOW: begin
                    if (!differs) begin
                        cnt_d = '0;
                    end else if (cnt_q == LIM) begin
                        st_d  = F_HIGH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                F_HIGH: begin
                    if (!differs) begin
                        cnt_d = '0;
                    end else if (cnt_q == LIM) begin
                        st_d  = F_LOW;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_d  = F_LOW;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= F_LOW;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output.
    always_comb begin
        filt = (st_q == F_HIGH);
    end

    // R3
    early_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && cnt_q != LIM) |=> $stable(filt));

    // R2
    stable_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !differs) |=> (cnt_q == '0) && $stable(filt));

endmodule

// File: rtl/leg_interlock_fsm.sv
module leg_interlock_fsm
    import leg_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic hi_req,
    input  logic lo_req,
    output logic hi_gate,
    output logic lo_gate
);

    localparam int unsigned DW  = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DLIM = DW'(DEAD_CYC - 1);

    leg_state_e    state_q;
    leg_state_e    state_d;
    leg_owner_e    last_q;
    leg_owner_e    last_d;
    logic [DW-1:0] dcnt_q;
    logic [DW-1:0] dcnt_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        last_d  = last_q;
        dcnt_d  = dcnt_q;
        if (trip) begin
            state_d = S_DEAD;
            last_d  = OWN_NONE;
            dcnt_d  = '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (hi_req && lo_req) begin
                        state_d = S_BLOCK;
                    end else if (hi_req) begin
                        state_d = S_HI;
                    end else if (lo_req) begin
                        state_d = S_LO;
                    end
                end
                S_HI: begin
                    if (!hi_req) begin
                        state_d = S_DEAD;
                        last_d  = OWN_HI;
                        dcnt_d  = '0;
                    end
                end
                S_LO: begin
                    if (!lo_req) begin
                        state_d = S_DEAD;
                        last_d  = OWN_LO;
                        dcnt_d  = '0;
                    end
                end
                S_DEAD: begin
                    if (dcnt_q == DLIM) begin
                        dcnt_d = '0;
                        if (hi_req && lo_req) begin
                            unique case (last_q)
                                OWN_HI:  state_d = S_LO;
                                OWN_LO:  state_d = S_HI;
                                default: state_d = S_BLOCK;
                            endcase
                        end else if (hi_req) begin
                            state_d = S_HI;
                        end else if (lo_req) begin
                            state_d = S_LO;
                        end else begin
                            state_d = S_IDLE;
                        end
                    end else begin
                        dcnt_d = dcnt_q + 1'b1;
                    end
                end
                S_BLOCK: begin
                    if (hi_req && !lo_req) begin
                        state_d = S_HI;
                    end else if (lo_req && !hi_req) begin
                        state_d = S_LO;
                    end else if (!hi_req && !lo_req) begin
                        state_d = S_IDLE;
                    end
                end
                default: begin
                    state_d = S_DEAD;
                    last_d  = OWN_NONE;
                    dcnt_d  = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_DEAD;
            last_q  <= OWN_NONE;
            dcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            last_q  <= last_d;
            dcnt_q  <= dcnt_d;
        end
    end

    // Outputs: a trip gates both enables in the same cycle.
    always_comb begin
        hi_gate = (state_q == S_HI) && !trip;
        lo_gate = (state_q == S_LO) && !trip;
    end

    // R4
    owner_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HI && hi_req && !trip) |=> (state_q == S_HI));

    // R4
    owner_holds_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LO && lo_req && !trip) |=> (state_q == S_LO));

    // R8
    tie_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && hi_req && lo_req && !trip) |=> (!hi_gate && !lo_gate));

    // R10
    trip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (state_q == S_DEAD && dcnt_q == '0) || trip);

endmodule

// File: rtl/leg_gate_cond.sv
module leg_gate_cond
    import leg_pkg::*;
#(
    parameter int unsigned FILT_CYC = 29,
    parameter int unsigned DEAD_CYC = 38
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic trip,
    output logic hi_gate,
    output logic lo_gate
);

    localparam int unsigned GW = (DEAD_CYC < 2) ? 2 : $clog2(DEAD_CYC + 1) + 1;

    logic [N_CH-1:0] cmd_raw;
    logic [N_CH-1:0] cmd_sync;
    logic [N_CH-1:0] cmd_filt;

    assign cmd_raw[CH_HI] = hi_cmd;
    assign cmd_raw[CH_LO] = lo_cmd;

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        leg_sync2 u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (cmd_raw[c]),
            .q_sync  (cmd_sync[c])
        );

        leg_glitch_filter #(
            .FILT_CYC (FILT_CYC)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (trip),
            .raw   (cmd_sync[c]),
            .filt  (cmd_filt[c])
        );
    end

    leg_interlock_fsm #(
        .DEAD_CYC (DEAD_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (trip),
        .hi_req  (cmd_filt[CH_HI]),
        .lo_req  (cmd_filt[CH_LO]),
        .hi_gate (hi_gate),
        .lo_gate (lo_gate)
    );

    // Cycles with both enables low, saturating at the dead time (checking only).
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (hi_gate || lo_gate) begin
            gap_q <= '0;
        end else if (gap_q < GW'(DEAD_CYC)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R6
    dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_gate) || $rose(lo_gate)) |-> (gap_q >= GW'(DEAD_CYC)));

    // R7
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_gate && lo_gate));

    // R9
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (!hi_gate && !lo_gate));

endmodule

// File: tb/test_leg_gate_cond.sv
module test_leg_gate_cond;

    localparam int unsigned F   = 6;
    localparam int unsigned D   = 9;
    localparam int unsigned REL = (D > F + 1) ? D : F + 1;
    localparam int unsigned WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd = 1'b0;
    logic trip = 1'b0;
    logic hi_gate;
    logic lo_gate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    leg_gate_cond #(.FILT_CYC(F), .DEAD_CYC(D)) i_leg_gate_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_cmd  (hi_cmd),
        .lo_cmd  (lo_cmd),
        .trip    (trip),
        .hi_gate (hi_gate),
        .lo_gate (lo_gate)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        hi_cmd = 1'b0;
        lo_cmd = 1'b0;
        trip   = 1'b0;
        step(F + D + 12);
    endtask

    // R6 and R7 monitor, sampled between edges.
    int  gap = 0;
    logic prev_hi = 1'b0;
    logic prev_lo = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hi_gate && lo_gate) begin
                errors++;
                $display("FAIL R7 overlap: actual hi=%b lo=%b expected not both 1", hi_gate, lo_gate);
            end
            if ((hi_gate && !prev_hi) || (lo_gate && !prev_lo)) begin
                checks++;
                if (gap < D) begin
                    errors++;
                    $display("FAIL R6 dead gap: actual %0d expected >= %0d", gap, D);
                end
            end
            if (hi_gate || lo_gate) gap = 0;
            else if (gap < D) gap++;
            prev_hi = hi_gate;
            prev_lo = lo_gate;
        end
    end

    task automatic t_reset();
        step(3);
        chk("R1", "hi_gate in reset", hi_gate, 1'b0);
        chk("R1", "lo_gate in reset", lo_gate, 1'b0);
        rst_n = 1'b1;
        step(D + 4);
        chk("R1", "hi_gate after reset", hi_gate, 1'b0);
        chk("R1", "lo_gate after reset", lo_gate, 1'b0);
    endtask

    task automatic t_latency();
        hi_cmd = 1'b1;
        step(F + 2);
        chk("R2", "hi on one edge early", hi_gate, 1'b0);
        step(1);
        chk("R2", "hi on when due", hi_gate, 1'b1);
        hi_cmd = 1'b0;
        step(F + 2);
        chk("R2", "hi off one edge early", hi_gate, 1'b1);
        step(1);
        chk("R2", "hi off when due", hi_gate, 1'b0);
        settle();
        lo_cmd = 1'b1;
        step(F + 2);
        chk("R2", "lo on one edge early", lo_gate, 1'b0);
        step(1);
        chk("R2", "lo on when due", lo_gate, 1'b1);
        settle();
    endtask

    task automatic t_filter();
        logic seen;
        hi_cmd = 1'b1;
        step(F - 1);
        hi_cmd = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < F + 10; i++) begin
            step(1);
            seen = seen | hi_gate;
        end
        chk("R3", "short high pulse rejected", seen, 1'b0);
        hi_cmd = 1'b1;
        step(F);
        hi_cmd = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < F + 10; i++) begin
            step(1);
            seen = seen | hi_gate;
        end
        chk("R3", "full-length pulse passed", seen, 1'b1);
        settle();
        lo_cmd = 1'b1;
        step(F + 4);
        chk("R3", "lo on before dip", lo_gate, 1'b1);
        lo_cmd = 1'b0;
        step(F - 1);
        lo_cmd = 1'b1;
        seen = 1'b1;
        for (int i = 0; i < F + 10; i++) begin
            step(1);
            seen = seen & lo_gate;
        end
        chk("R3", "short low dip rejected", seen, 1'b1);
        settle();
    endtask

    task automatic t_first_come_handover();
        logic seen;
        hi_cmd = 1'b1;
        step(F + 4);
        lo_cmd = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 3 * F; i++) begin
            step(1);
            seen = seen | lo_gate;
        end
        chk("R4", "waiting lo held off", seen, 1'b0);
        chk("R4", "owner hi stays on", hi_gate, 1'b1);
        hi_cmd = 1'b0;
        step(F + 2);
        chk("R5", "hi still on", hi_gate, 1'b1);
        step(1);
        chk("R5", "hi off", hi_gate, 1'b0);
        step(D - 1);
        chk("R5", "lo off one cycle before dead time ends", lo_gate, 1'b0);
        step(1);
        chk("R5", "lo on after dead time", lo_gate, 1'b1);
        settle();
    endtask

    task automatic t_waiting_wins();
        hi_cmd = 1'b1;
        step(F + 4);
        lo_cmd = 1'b1;
        step(F + 4);
        hi_cmd = 1'b0;
        step(F + 2);
        hi_cmd = 1'b1;
        step(1);
        chk("R11", "hi off", hi_gate, 1'b0);
        step(D - 1);
        chk("R11", "lo off before dead time ends", lo_gate, 1'b0);
        step(1);
        chk("R11", "waiting lo wins", lo_gate, 1'b1);
        chk("R11", "returning hi held off", hi_gate, 1'b0);
        step(2 * F);
        chk("R11", "hi still held off", hi_gate, 1'b0);
        settle();
    endtask

    task automatic t_simultaneous();
        logic seen;
        hi_cmd = 1'b1;
        lo_cmd = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 3 * F + 4; i++) begin
            step(1);
            seen = seen | hi_gate | lo_gate;
        end
        chk("R8", "tie keeps both off", seen, 1'b0);
        lo_cmd = 1'b0;
        step(F + 2);
        chk("R8", "hi off one edge early", hi_gate, 1'b0);
        step(1);
        chk("R8", "hi on after lo release", hi_gate, 1'b1);
        settle();
    endtask

    task automatic t_trip();
        hi_cmd = 1'b1;
        step(F + 4);
        chk("R9", "hi on before trip", hi_gate, 1'b1);
        trip = 1'b1;
        #1;
        chk("R9", "hi off same cycle", hi_gate, 1'b0);
        chk("R9", "lo off same cycle", lo_gate, 1'b0);
        lo_cmd = 1'b1;
        step(5);
        chk("R9", "hi off during trip", hi_gate, 1'b0);
        lo_cmd = 1'b0;
        step(F + 3);
        trip = 1'b0;
        step(REL - 1);
        chk("R10", "hi off one edge early", hi_gate, 1'b0);
        step(1);
        chk("R10", "hi on after refilter", hi_gate, 1'b1);
        settle();
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_filter();
        t_first_come_handover();
        t_waiting_wins();
        t_simultaneous();
        t_trip();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule